// File: doc/BRIEF.md
# Pin-Strapped I2C Control Register Target

This block is the serial control port of a small multi-channel control chip. It acts as an I2C target on an open-drain bus and holds four 8-bit control words: one for each of three channels and one that governs sync and shutdown. An external controller reaches these words through a subaddress byte. The controller first writes a subaddress, then either writes exactly one data byte to it or, after a repeated START, reads the selected word back.

The 7-bit target address is a fixed five-bit prefix followed by the two address pins. The pins are not latched, so each address byte is compared with the levels the pins have while that byte arrives. A strap pin, sampled during reset, chooses between two reset images: all words cleared, or a powered-up preset. The preset stays in place until the first data byte is accepted.

SCL and SDA enter through two-flop synchronisers clocked by a faster system clock. The block drives the bus only by pulling SDA low.

Top module: `i2c_strap_regs`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal {01011, a1_i, a0_i}. Bit 0 of the address byte selects write (0) or read (1). Any other address byte is not acknowledged, and the block waits for the next START.
- R2: The address pins are compared with the levels present during each address byte, so changing them between transactions changes which address is answered.
- R3: A subaddress byte is acknowledged only when it is 0x01, 0x02, 0x03 (channel words 1 to 3) or 0x04 (sync word). Any other value is not acknowledged and leaves every register unchanged.
- R4: In a write, the byte after an accepted subaddress is acknowledged and stored in the register that the subaddress names.
- R5: In a write, any data byte after the first is not acknowledged and changes no register.
- R6: In a read, the target sends the most recently selected register, MSB first, pulling SDA low only for 0 bits.
- R7: If pwr_strap_i is low during reset, all four registers reset to 8'h00.
- R8: If pwr_strap_i is high during reset, the three channel registers reset to 8'h0D and the sync register to 8'h01.
- R9: A repeated START at any point restarts address decoding with a new address byte.
- R10: After the controller does not acknowledge a read byte, the target releases SDA and drives nothing more until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | When high, pulls SDA low |
| a1_i | input | 1 | Address pin, target address bit 1 |
| a0_i | input | 1 | Address pin, target address bit 0 |
| pwr_strap_i | input | 1 | Selects the reset image |
| ch1_o | output | 8 | Channel 1 control word |
| ch2_o | output | 8 | Channel 2 control word |
| ch3_o | output | 8 | Channel 3 control word |
| sync_o | output | 8 | Sync and shutdown control word |

## Verification
A stale subaddress pointer or a bit counter that has slipped does not stay hidden. It appears at once as a wrong ACK bit on the bus, or as a data byte landing in a neighbouring register output one transaction later. A byte sent with the wrong bit order or wrong polarity appears in the first read that follows. A target that keeps driving after a controller NACK shows as SDA held low during the next low phase of SCL. Each scenario therefore checks the ACK bits, the register outputs and the read data immediately after the byte concerned.

// File: rtl/i2c_strap_regs.sv
module i2c_strap_regs #(
  parameter logic [4:0] ADDR_PREFIX = 5'b01011,
  parameter logic [7:0] CH_ON_INIT  = 8'h0D,
  parameter logic [7:0] SYNC_ON_INIT = 8'h01,
  parameter logic [7:0] OFF_INIT    = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       a1_i,
  input  logic       a0_i,
  input  logic       pwr_strap_i,
  output logic [7:0] ch1_o,
  output logic [7:0] ch2_o,
  output logic [7:0] ch3_o,
  output logic [7:0] sync_o
);
  localparam int NREG = 4;
  localparam logic [3:0] BYTE_END = 4'd8;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_WDATA, S_EXTRA, S_RDATA} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end
  end

  wire scl      = scl_s[1];
  wire sda      = sda_s[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;

  st_t        st;
  logic [3:0] bits;
  logic [7:0] shreg, tx;
  logic       in_ack, drive, rd_mode;
  logic [2:0] sel;
  logic [7:0] regs [NREG];

  wire [6:0] my_addr = {ADDR_PREFIX, a1_i, a0_i};
  wire       sub_ok  = (shreg >= 8'd1) && (shreg <= 8'd4);
  wire [1:0] sel_idx = sel[1:0] - 2'd1;
  wire [7:0] cur     = regs[sel_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bits <= '0; shreg <= '0; tx <= '0;
      in_ack <= 1'b0; drive <= 1'b0; rd_mode <= 1'b0; sel <= 3'd1;
      for (int k = 0; k < NREG; k++)
        regs[k] <= !pwr_strap_i ? OFF_INIT : (k == NREG-1) ? SYNC_ON_INIT : CH_ON_INIT;
    end else if (start_c) begin
      st <= S_ADDR; bits <= '0; in_ack <= 1'b0; drive <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; in_ack <= 1'b0; drive <= 1'b0;
    end else if (st == S_RDATA) begin
      if (scl_rise) begin
        if (bits == BYTE_END) begin
          if (sda) st <= S_IDLE;
          else begin bits <= '0; tx <= cur; end
        end else bits <= bits + 4'd1;
      end else if (scl_fall) begin
        drive <= (bits < BYTE_END) ? ~tx[3'd7 - bits[2:0]] : 1'b0;
      end
    end else if (st != S_IDLE) begin
      if (scl_rise && !in_ack && bits < BYTE_END) begin
        shreg <= {shreg[6:0], sda};
        bits  <= bits + 4'd1;
      end else if (scl_fall && !in_ack && bits == BYTE_END) begin
        in_ack <= 1'b1;
        case (st)
          S_ADDR:  if (shreg[7:1] == my_addr) begin drive <= 1'b1; rd_mode <= shreg[0]; end
                   else st <= S_IDLE;
          S_SUB:   if (sub_ok) begin drive <= 1'b1; sel <= shreg[2:0]; end
                   else st <= S_IDLE;
          S_WDATA: begin drive <= 1'b1; regs[sel_idx] <= shreg; end
          default: st <= S_IDLE;
        endcase
      end else if (scl_fall && in_ack) begin
        in_ack <= 1'b0;
        bits   <= '0;
        drive  <= 1'b0;
        case (st)
          S_ADDR:  if (rd_mode) begin st <= S_RDATA; tx <= cur; drive <= ~cur[7]; end
                   else st <= S_SUB;
          S_SUB:   st <= S_WDATA;
          S_WDATA: st <= S_EXTRA;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe = drive;
  assign ch1_o  = regs[0];
  assign ch2_o  = regs[1];
  assign ch3_o  = regs[2];
  assign sync_o = regs[3];

  // R4
  reg_write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({ch1_o, ch2_o, ch3_o, sync_o}) |-> ($past(st) == S_WDATA));

  // R6
  drive_on_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_c) || $past(stop_c)));

  // R10
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R3
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel >= 3'd1) && (sel <= 3'd4));

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_ADDR) && !sda_oe);
endmodule

// File: tb/i2c_strap_regs_tb.sv
module i2c_strap_regs_tb_top;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, a1 = 1'b0, a0 = 1'b0, strap = 1'b0;
  logic sda_oe;
  logic [7:0] ch1, ch2, ch3, syn;
  logic [7:0] exp_r [4];
  int errors = 0, checks = 0;
  bit done = 0;

  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_strap_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .a1_i(a1), .a0_i(a0), .pwr_strap_i(strap),
    .ch1_o(ch1), .ch2_o(ch2), .ch3_o(ch3), .sync_o(syn));

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic chk_regs(input string tag);
    chk(tag, ch1, exp_r[0]); chk(tag, ch2, exp_r[1]);
    chk(tag, ch3, exp_r[2]); chk(tag, syn, exp_r[3]);
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); d[i] = sda_line; wq(); scl_m = 1'b0;
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] abyte(input logic p1, input logic p0, input logic rd);
    return {5'b01011, p1, p0, rd};
  endfunction

  task automatic write_reg(input logic [7:0] sub, input logic [7:0] d, input string tag);
    logic ack;
    i2c_start();
    send_byte(abyte(a1, a0, 1'b0), ack); chk({tag, " R1 addr ack"}, ack, 1'b1);
    send_byte(sub, ack);                chk({tag, " R3 sub ack"}, ack, 1'b1);
    send_byte(d, ack);                  chk({tag, " R4 data ack"}, ack, 1'b1);
    i2c_stop();
    exp_r[sub - 1] = d;
  endtask

  task automatic read_reg(input logic [7:0] sub, output logic [7:0] d);
    logic ack;
    i2c_start();
    send_byte(abyte(a1, a0, 1'b0), ack); chk("R1 sel addr ack", ack, 1'b1);
    send_byte(sub, ack);                chk("R3 sel sub ack", ack, 1'b1);
    i2c_start();
    send_byte(abyte(a1, a0, 1'b1), ack); chk("R9 restart read addr ack", ack, 1'b1);
    recv_byte(1'b0, d);
    wq();
    chk("R10 sda released after nack", sda_line, 1'b1);
    i2c_stop();
  endtask

  task automatic t_reset_off();
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) exp_r[k] = 8'h00;
    chk_regs("R7 reset strap low");
    chk("R7 sda idle", sda_oe, 1'b0);
  endtask

  task automatic t_reset_on();
    do_reset(1'b1);
    exp_r[0] = 8'h0D; exp_r[1] = 8'h0D; exp_r[2] = 8'h0D; exp_r[3] = 8'h01;
    chk_regs("R8 reset strap high");
  endtask

  task automatic t_write_all();
    a1 = 1'b0; a0 = 1'b0;
    write_reg(8'h01, 8'hA5, "w1");
    write_reg(8'h02, 8'h3C, "w2");
    write_reg(8'h03, 8'h81, "w3");
    write_reg(8'h04, 8'h7E, "w4");
    chk_regs("R4 all four written");
  endtask

  task automatic t_wrong_addr();
    logic ack;
    i2c_start();
    send_byte({5'b01010, a1, a0, 1'b0}, ack); chk("R1 wrong prefix nack", ack, 1'b0);
    send_byte(8'h01, ack);                    chk("R1 ignored after nack", ack, 1'b0);
    send_byte(8'hFF, ack);
    i2c_stop();
    chk_regs("R1 regs unchanged");
  endtask

  task automatic t_live_pins();
    logic ack;
    a1 = 1'b1; a0 = 1'b0;
    i2c_start();
    send_byte(abyte(1'b0, 1'b0, 1'b0), ack); chk("R2 old pins nack", ack, 1'b0);
    i2c_stop();
    write_reg(8'h01, 8'h11, "R2 new pins");
    a1 = 1'b1; a0 = 1'b1;
    write_reg(8'h04, 8'h22, "R2 pins 11");
    chk_regs("R2 regs after pin change");
  endtask

  task automatic t_bad_sub();
    logic ack;
    i2c_start();
    send_byte(abyte(a1, a0, 1'b0), ack); chk("R3 addr ack", ack, 1'b1);
    send_byte(8'h05, ack);              chk("R3 sub 05 nack", ack, 1'b0);
    send_byte(8'h99, ack);
    i2c_stop();
    i2c_start();
    send_byte(abyte(a1, a0, 1'b0), ack);
    send_byte(8'h00, ack);              chk("R3 sub 00 nack", ack, 1'b0);
    send_byte(8'h66, ack);
    i2c_stop();
    chk_regs("R3 regs unchanged");
  endtask

  task automatic t_extra();
    logic ack;
    i2c_start();
    send_byte(abyte(a1, a0, 1'b0), ack);
    send_byte(8'h02, ack);
    send_byte(8'h55, ack); chk("R5 first data ack", ack, 1'b1);
    send_byte(8'hAA, ack); chk("R5 extra data nack", ack, 1'b0);
    i2c_stop();
    exp_r[1] = 8'h55;
    chk_regs("R5 only first byte stored");
  endtask

  task automatic t_read();
    logic [7:0] d;
    read_reg(8'h03, d); chk("R6 read ch3", d, exp_r[2]);
    read_reg(8'h02, d); chk("R6 read ch2", d, exp_r[1]);
    read_reg(8'h04, d); chk("R6 read sync", d, exp_r[3]);
  endtask

  task automatic t_restart();
    logic ack;
    logic [7:0] d;
    i2c_start();
    send_byte({5'b11111, a1, a0, 1'b0}, ack); chk("R9 foreign addr nack", ack, 1'b0);
    i2c_start();
    send_byte(abyte(a1, a0, 1'b0), ack); chk("R9 addr after restart", ack, 1'b1);
    send_byte(8'h01, ack);
    i2c_start();
    send_byte(abyte(a1, a0, 1'b1), ack); chk("R9 read after restart", ack, 1'b1);
    recv_byte(1'b0, d); chk("R9 read ch1", d, exp_r[0]);
    i2c_stop();
  endtask

  initial begin
    t_reset_off();
    t_reset_on();
    t_write_all();
    t_wrong_addr();
    t_live_pins();
    t_bad_sub();
    t_extra();
    t_read();
    t_restart();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule